// File: doc/BRIEF.md
# Quad I/O Serial Flash Read Controller

This block sits on the host side of a serial flash device and runs quad-I/O fast reads. A requester asks for a read by presenting a 24-bit start address and a mode byte. The controller lowers chip select and sends the read opcode serially on data line 0. It then puts the address and the mode byte on all four data lines, a nibble per serial clock. After a fixed number of dummy clocks, during which it releases the lines, it collects returned bytes one nibble per clock. Each assembled byte goes back to the requester as a one-cycle valid pulse. The burst runs until the requester asks it to stop, and a stop always completes the byte in flight.

The serial clock runs at half the system clock. The requester chooses whether the clock idles low or high (SPI modes 0 and 3). If the mode byte of a read has bits 5:4 equal to binary 10, the flash stays in continuous-read state. The controller tracks this and leaves out the opcode on the next read, which then starts straight with the address.

Top module: `quad_read_ctrl`

## Requirements
- R1: During and right after reset, `csN` is high, `busy` and `dataValid` are low, `ioOe` is 0, and `sclk` equals `sclkIdleHigh`.
- R2: A read that is not in continuous state first shifts opcode 0xEB out on `ioOut[0]` over 8 serial clocks, MSB first, with `ioOe` = 4'b0001.
- R3: The address then goes out over 6 serial clocks as nibbles on `ioOut[3:0]`, most significant nibble first (bit 23 on line 3 in the first clock). The mode byte follows over 2 clocks, high nibble first. `ioOe` = 4'hF throughout.
- R4: Four dummy clocks follow the mode byte. `ioOe` is 0 from the first dummy clock until the end of the burst.
- R5: In the data phase `ioIn` is sampled at each rising `sclk` edge. Two clocks form one byte, high nibble first. Each byte is presented on `dataByte` with `dataValid` high for exactly one system cycle, in the order received.
- R6: If the previous read's mode byte had bits 5:4 = 2'b10, the next read omits the opcode phase and starts with the address. Any other value makes the next read include the opcode. After reset the first read includes it.
- R7: `reqStop` ends the burst after the byte in progress, and that byte is still delivered. A stop seen before the data phase yields exactly one byte. A stop raised in the cycle of the n-th `dataValid` yields exactly n bytes.
- R8: After a burst, `csN` stays high for at least two system cycles (one serial clock period) before it can fall again. `csN` falls only after an accepted `reqValid` while idle. `reqValid` is ignored while `busy` is high.
- R9: While `csN` is high, `sclk` sits at the level given by `sclkIdleHigh`. While selected, each serial clock is one system cycle low followed by one cycle high.
- R10: A burst of n bytes has exactly header + 2n rising `sclk` edges while selected. The header is 20 edges with the opcode and 12 without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIdleHigh | input | 1 | Serial clock idle level: 0 low (mode 0), 1 high (mode 3) |
| reqValid | input | 1 | Start a read (taken only when not busy) |
| reqAddr | input | 24 | Start address of the read |
| reqMode | input | 8 | Mode byte sent after the address |
| reqStop | input | 1 | End the burst after the current byte |
| busy | output | 1 | A read or the post-burst deselect gap is in progress |
| dataValid | output | 1 | One-cycle strobe for `dataByte` |
| dataByte | output | 8 | Received byte |
| csN | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Serial clock to the flash |
| ioOut | output | 4 | Values driven on the four data lines |
| ioOe | output | 4 | Per-line output enable, 1 = host drives |
| ioIn | input | 4 | Values read from the four data lines |

## Verification
A behavioural flash model decodes the header from the edges it sees and answers with address-dependent bytes. A controller that got the continuous-read rule wrong would misalign the model's decode and return the wrong address and data, and it would also give the wrong count of rising edges. Stop requests arrive early, during the header, and together with the last wanted byte. A controller that dropped the byte in flight, or ran one byte too long, shows up in the byte count. The bench also targets late output-enable release, a too-short deselect gap, a request poked in mid-burst, a wrong idle clock level in either mode, and an address at the top of the space.

// File: rtl/qrd_pkg.sv
package qrd_pkg;
  localparam int NIB_W = 4;
  localparam int CMD_BEATS = 8;
  localparam logic [7:0] READ_OP = 8'hEB;
  localparam logic [1:0] CONT_CODE = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_MODE, ST_DUMMY, ST_DATA, ST_GAP
  } rdState_e;

  typedef enum logic [1:0] {
    DRV_NONE, DRV_OP, DRV_NIB
  } drvSel_e;

  typedef struct packed {
    logic     load;
    logic     shiftOut;
    logic     capture;
    logic     emit;
    drvSel_e  drvSel;
    logic [2:0] opBit;
  } ctlStrobe_t;
endpackage

// File: rtl/qrd_ctrl.sv
module qrd_ctrl
  import qrd_pkg::*;
#(
  parameter int ADDR_BEATS  = 6,
  parameter int MODE_BEATS  = 2,
  parameter int DUMMY_BEATS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkIdleHigh,
  input  logic       reqValid,
  input  logic [1:0] reqModeHi,
  input  logic       reqStop,
  output logic       csN,
  output logic       sclk,
  output logic       busy,
  output ctlStrobe_t strobe
);
  localparam int MAXA = (CMD_BEATS > ADDR_BEATS) ? CMD_BEATS : ADDR_BEATS;
  localparam int MAXB = (MAXA > DUMMY_BEATS) ? MAXA : DUMMY_BEATS;
  localparam int MAXC = (MAXB > MODE_BEATS) ? MAXB : MODE_BEATS;
  localparam int BEAT_W = (MAXC > 2) ? $clog2(MAXC) : 1;

  rdState_e          state;
  rdState_e          nextPhase;
  logic              phase;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] lastBeat;
  logic              contMode;
  logic              stopPend;

  always_comb begin
    lastBeat  = '0;
    nextPhase = ST_IDLE;
    case (state)
      ST_CMD:   begin lastBeat = BEAT_W'(CMD_BEATS - 1);   nextPhase = ST_ADDR;  end
      ST_ADDR:  begin lastBeat = BEAT_W'(ADDR_BEATS - 1);  nextPhase = ST_MODE;  end
      ST_MODE:  begin lastBeat = BEAT_W'(MODE_BEATS - 1);  nextPhase = ST_DUMMY; end
      ST_DUMMY: begin lastBeat = BEAT_W'(DUMMY_BEATS - 1); nextPhase = ST_DATA;  end
      default:  begin lastBeat = '0;                       nextPhase = ST_IDLE;  end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phase    <= 1'b0;
      beat     <= '0;
      contMode <= 1'b0;
      stopPend <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state    <= contMode ? ST_ADDR : ST_CMD;
            contMode <= (reqModeHi == CONT_CODE);
            phase    <= 1'b0;
            beat     <= '0;
            stopPend <= 1'b0;
          end
        end
        ST_GAP: begin
          phase <= ~phase;
          if (phase) state <= ST_IDLE;
        end
        default: begin
          if (reqStop) stopPend <= 1'b1;
          phase <= ~phase;
          if (phase) begin
            if (state == ST_DATA) begin
              beat <= beat ^ BEAT_W'(1);
              if (beat[0] && (stopPend || reqStop)) state <= ST_GAP;
            end else if (beat == lastBeat) begin
              beat  <= '0;
              state <= nextPhase;
            end else begin
              beat <= beat + BEAT_W'(1);
            end
          end
        end
      endcase
    end
  end

  assign csN  = (state == ST_IDLE) || (state == ST_GAP);
  assign sclk = csN ? sclkIdleHigh : phase;
  assign busy = (state != ST_IDLE);

  always_comb begin
    strobe          = '0;
    strobe.load     = (state == ST_IDLE) && reqValid;
    strobe.shiftOut = phase && ((state == ST_ADDR) || (state == ST_MODE));
    strobe.capture  = !phase && (state == ST_DATA);
    strobe.emit     = !phase && (state == ST_DATA) && beat[0];
    strobe.opBit    = 3'(BEAT_W'(CMD_BEATS - 1) - beat);
    case (state)
      ST_CMD:           strobe.drvSel = DRV_OP;
      ST_ADDR, ST_MODE: strobe.drvSel = DRV_NIB;
      default:          strobe.drvSel = DRV_NONE;
    endcase
  end

  AST_SCLK_TOGGLES: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && $past(!csN)) |-> (sclk != $past(sclk))); // R9
  AST_GAP_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |=> csN); // R8
  AST_GAP_SECOND: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |=> ##1 csN); // R8
  AST_START_ON_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> $past(reqValid)); // R8
endmodule

// File: rtl/qrd_datapath.sv
module qrd_datapath
  import qrd_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int MODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [MODE_W-1:0] reqMode,
  input  logic [3:0]        ioIn,
  output logic [3:0]        ioOut,
  output logic [3:0]        ioOe,
  output logic              dataValid,
  output logic [7:0]        dataByte
);
  localparam int SH_W = ADDR_W + MODE_W;

  logic [SH_W-1:0]  sendReg;
  logic [NIB_W-1:0] rxNib;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sendReg   <= '0;
      rxNib     <= '0;
      dataValid <= 1'b0;
      dataByte  <= '0;
    end else begin
      if (strobe.load)          sendReg <= {reqAddr, reqMode};
      else if (strobe.shiftOut) sendReg <= sendReg << NIB_W;
      if (strobe.capture) rxNib <= ioIn;
      dataValid <= strobe.emit;
      if (strobe.emit) dataByte <= {rxNib, ioIn};
    end
  end

  always_comb begin
    case (strobe.drvSel)
      DRV_OP:  begin ioOut = {3'b000, READ_OP[strobe.opBit]}; ioOe = 4'b0001; end
      DRV_NIB: begin ioOut = sendReg[SH_W-1 -: NIB_W];       ioOe = 4'b1111; end
      default: begin ioOut = 4'b0000;                         ioOe = 4'b0000; end
    endcase
  end

  AST_RELEASED_IN_DATA: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |-> (ioOe == 4'b0000)); // R4
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid); // R5
endmodule

// File: rtl/quad_read_ctrl.sv
module quad_read_ctrl
  import qrd_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int MODE_W      = 8,
  parameter int DUMMY_BEATS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIdleHigh,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [MODE_W-1:0] reqMode,
  input  logic              reqStop,
  output logic              busy,
  output logic              dataValid,
  output logic [7:0]        dataByte,
  output logic              csN,
  output logic              sclk,
  output logic [3:0]        ioOut,
  output logic [3:0]        ioOe,
  input  logic [3:0]        ioIn
);
  localparam int ADDR_BEATS = ADDR_W / NIB_W;
  localparam int MODE_BEATS = MODE_W / NIB_W;

  ctlStrobe_t strobe;

  qrd_ctrl #(
    .ADDR_BEATS (ADDR_BEATS),
    .MODE_BEATS (MODE_BEATS),
    .DUMMY_BEATS(DUMMY_BEATS)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .sclkIdleHigh(sclkIdleHigh),
    .reqValid    (reqValid),
    .reqModeHi   (reqMode[5:4]),
    .reqStop     (reqStop),
    .csN         (csN),
    .sclk        (sclk),
    .busy        (busy),
    .strobe      (strobe)
  );

  qrd_datapath #(
    .ADDR_W(ADDR_W),
    .MODE_W(MODE_W)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqMode  (reqMode),
    .ioIn     (ioIn),
    .ioOut    (ioOut),
    .ioOe     (ioOe),
    .dataValid(dataValid),
    .dataByte (dataByte)
  );
endmodule

// File: tb/sim_quad_read_ctrl.sv
module sim_quad_read_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclkIdleHigh = 1'b0;
  logic        reqValid = 1'b0;
  logic [23:0] reqAddr = '0;
  logic [7:0]  reqMode = '0;
  logic        reqStop = 1'b0;
  logic        busy, dataValid, csN, sclk;
  logic [7:0]  dataByte;
  logic [3:0]  ioOut, ioOe;
  logic [3:0]  ioIn = 4'h0;

  int checks = 0;
  int errors = 0;
  bit prevCont = 1'b0;

  quad_read_ctrl u0 (
    .clk(clk), .rstN(rstN), .sclkIdleHigh(sclkIdleHigh), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqMode(reqMode), .reqStop(reqStop), .busy(busy),
    .dataValid(dataValid), .dataByte(dataByte), .csN(csN), .sclk(sclk),
    .ioOut(ioOut), .ioOe(ioOe), .ioIn(ioIn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] memByte(input logic [23:0] a);
    return (a[7:0] * 8'd7) + a[15:8] + {a[19:16], a[23:20]} + 8'h3C;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // flash model
  int rcnt = 0, nib = 0, hdr = 20, oeBad = 0, h = 0;
  bit skip = 1'b0;
  logic [7:0]  opRx = '0;
  logic [7:0]  mdRx = 8'h00;
  logic [23:0] adRx = '0;

  always @(negedge csN) begin
    rcnt = 0; nib = 0; opRx = '0;
    hdr = skip ? 12 : 20;
  end
  always @(posedge csN) skip = (mdRx[5:4] == 2'b10);

  always @(posedge sclk) begin
    if (csN === 1'b0) begin
      if (rcnt < hdr) begin
        h = skip ? rcnt : rcnt - 8;
        if (!skip && rcnt < 8) begin
          opRx = {opRx[6:0], ioOut[0]};
          if (ioOe !== 4'b0001) oeBad++;
        end else if (h < 6) begin
          adRx = {adRx[19:0], ioOut};
          if (ioOe !== 4'hF) oeBad++;
        end else if (h < 8) begin
          mdRx = {mdRx[3:0], ioOut};
          if (ioOe !== 4'hF) oeBad++;
        end else if (ioOe !== 4'h0) oeBad++;
      end else if (ioOe !== 4'h0) oeBad++;
      rcnt++;
    end
  end

  always @(negedge sclk) begin
    if (csN === 1'b0 && rcnt >= hdr) begin
      ioIn = nib[0] ? memByte(adRx + 24'(nib/2))[3:0] : memByte(adRx + 24'(nib/2))[7:4];
      nib++;
    end
  end

  // deselect run length
  int hiRun = 0, minHi = 1000;
  always @(negedge clk) begin
    if (rstN) begin
      if (csN) hiRun++;
      else begin
        if (hiRun > 0 && hiRun < minHi) minHi = hiRun;
        hiRun = 0;
      end
    end
  end

  task automatic doRead(input logic [23:0] a, input logic [7:0] m, input int n,
                        input bit cpol, input bit earlyStop, input bit poke);
    int got = 0;
    int cyc = 0;
    int expN = earlyStop ? 1 : n;
    while (busy) @(negedge clk);
    sclkIdleHigh = cpol;
    @(negedge clk);
    oeBad = 0;
    reqAddr = a; reqMode = m; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (busy && cyc < 2000) begin
      reqStop = 1'b0; reqValid = 1'b0;
      if (dataValid) begin
        check(dataByte == memByte(a + 24'(got)), "R5", "data byte", dataByte, memByte(a + 24'(got)));
        got++;
        if (got >= n) reqStop = 1'b1;
      end
      if (earlyStop && cyc == 3) reqStop = 1'b1;
      if (poke && cyc == 5) begin reqValid = 1'b1; reqAddr = ~a; end
      cyc++;
      @(negedge clk);
    end
    reqStop = 1'b0; reqValid = 1'b0;
    check(got == expN, "R7", "byte count", got, expN);
    if (!prevCont) check(opRx == 8'hEB, "R2", "opcode", opRx, 8'hEB);
    check(adRx == a, "R3", "address", adRx, a);
    check(mdRx == m, "R3", "mode byte", mdRx, m);
    check(oeBad == 0, "R4", "output enable misuse", oeBad, 0);
    check(rcnt == (prevCont ? 12 : 20) + 2*expN, "R6/R10", "rising edges", rcnt, (prevCont ? 12 : 20) + 2*expN);
    check(sclk == cpol, "R9", "idle clock level", sclk, cpol);
    prevCont = (m[5:4] == 2'b10);
    if (poke) begin
      repeat (8) @(negedge clk);
      check(!busy && csN, "R8", "request while busy ignored", busy, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(csN == 1'b1, "R1", "csN in reset", csN, 1);
    check(busy == 1'b0, "R1", "busy in reset", busy, 0);
    check(ioOe == 4'h0, "R1", "ioOe in reset", ioOe, 0);
    check(dataValid == 1'b0, "R1", "dataValid in reset", dataValid, 0);
    check(sclk == sclkIdleHigh, "R1", "sclk in reset", sclk, sclkIdleHigh);
    rstN = 1'b1;
    @(negedge clk);
    check(csN == 1'b1 && busy == 1'b0, "R1", "idle after reset", busy, 0);

    doRead(24'h123456, 8'h00, 4, 1'b0, 1'b0, 1'b0);  // R2 first read with opcode
    doRead(24'hABCDEF, 8'hA0, 3, 1'b0, 1'b0, 1'b0);  // sets continuous
    doRead(24'h000010, 8'h20, 2, 1'b1, 1'b0, 1'b0);  // R6 skip, stays continuous
    doRead(24'hFFFFFF, 8'hFF, 3, 1'b1, 1'b0, 1'b0);  // R6 skip, address top
    doRead(24'h00F0F0, 8'h10, 2, 1'b0, 1'b0, 1'b0);  // R6 opcode back
    doRead(24'h5A5A5A, 8'h00, 5, 1'b0, 1'b1, 1'b0);  // R7 early stop
    doRead(24'h0A0B0C, 8'h00, 1, 1'b1, 1'b0, 1'b1);  // R8 poke while busy
    for (int i = 0; i < 24; i++) begin
      logic [7:0] md;
      md = 8'($urandom);
      if ($urandom % 3 == 0) md[5:4] = 2'b10;
      doRead(24'($urandom), md, 1 + int'($urandom % 6), 1'($urandom), ($urandom % 7) == 0, 1'b0);
    end
    check(minHi >= 2, "R8", "deselect gap cycles", minHi, 2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule